// File: doc/BRIEF.md
# Single-Device Serial EEPROM Bit Engine

This block is a bit-level two-wire master meant for a bus that carries one serial EEPROM and nothing else. That memory answers to every 7-bit value in the first byte of a transfer, and it reads that value as a word offset, not as a device address. A controller above the engine issues one primitive at a time through a small command port. The primitives are bus recovery, start plus command byte, byte write, byte read with acknowledge, byte read without acknowledge, and stop. For each primitive the engine returns the received byte and an acknowledge flag. The controller uses these results to build complete reads and writes, and to decide when to abort.

Both lines are open-drain. The engine never drives a line high. It pulls a line low by asserting that line's output enable, and it lets the line float high by removing the enable. Bit timing comes from a half-period divider. Each SCL high or low phase lasts one half-period, and SDA is sampled only after SCL has been released for a full half-period.

Top module: `eeprom_i2c_engine`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both lines released) and `busy` and `done` are 0. While the engine is idle, neither enable changes unless a command is accepted.
- R2: Command code 1 sends a start and then the byte {cmd_data[6:0], cmd_rw}. The start releases SDA and SCL, pulls SDA low while SCL is high, then pulls SCL low. Offsets 0x00 and 0x7F are legal like any other.
- R3: Command code 2 sends cmd_data MSB first, one SCL pulse per bit. During data bits the engine changes SDA only while SCL is low.
- R4: After a transmitted byte, the engine releases SDA for a ninth SCL pulse and samples SDA at its end. A low level gives `nack`=0 and a high level gives `nack`=1. The result is held with `done`.
- R5: Command codes 3 and 4 read eight bits MSB first into `rx_byte`, sampling with SCL high. Code 3 then drives SDA low for a ninth pulse and releases it afterwards. Code 4 gives no ninth pulse.
- R6: Command code 5 pulls SCL low, pulls SDA low, releases SCL, then releases SDA while SCL is high. After SDA rises, `done` waits at least four half-periods.
- R7: Command code 0 pulls SCL low and releases SDA. It then repeats an attempt that releases SCL and samples SDA. The first attempt that sees SDA high pulls SDA low and then SCL low, and the command ends with `nack`=0.
- R8: If nine recovery attempts all see SDA low, the command ends with `nack`=1 after exactly nine SCL high pulses, with SCL low and SDA released.
- R9: A command is accepted only when `cmd_valid` is high, `busy` is low and the code is 0 to 5. `done` is a one-cycle pulse in the cycle where `busy` falls. Commands presented while busy, and codes 6 and 7, have no effect.
- R10: Every SCL high or low phase lasts at least HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 recover, 1 start, 2 write, 3 read+ack, 4 read+no-ack, 5 stop) |
| cmd_data | input | 8 | Byte to write; bits 6:0 give the offset for a start |
| cmd_rw | input | 1 | Direction bit sent in bit 0 of the start byte (1 read) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last received byte |
| nack | output | 1 | Acknowledge missing, or recovery failed |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A bench-side memory model watches the wire levels and answers on SDA from a pattern indexed by SCL falling edges. The address byte is tried with alternating bits (0xAB), all zeros and all ones below the R/W bit; a wrong shift direction or a misplaced R/W bit shows up as a different captured byte. Written and read bytes use complementary patterns (0xC3/0x3C, 0xA5/0x5A), with and without a slave acknowledge, which separates the acknowledge result from the data path and the ack-read from the no-ack read by their ninth pulse. Recovery is run against a bus that frees up at the first attempt, at the fourth attempt and never, which exposes off-by-one attempt limits.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  typedef enum logic [2:0] {
    OP_RECOVER   = 3'd0,
    OP_START     = 3'd1,
    OP_WRITE     = 3'd2,
    OP_READ_ACK  = 3'd3,
    OP_READ_NACK = 3'd4,
    OP_STOP      = 3'd5
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_STA0, S_STA1, S_STA2,
    S_WLO, S_WHI, S_ALO, S_AHI,
    S_RLO, S_RHI, S_MLO, S_MHI, S_MEND, S_TAIL,
    S_SP0, S_SP1, S_SP2, S_SP3, S_HOLD,
    S_RC0, S_RCH, S_RCL, S_RCD, S_RCC
  } seq_state_e;

endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int HALF_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = RELOAD;
    end else if (run) begin
      cnt_d = (cnt_q == '0) ? RELOAD : cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import eeprom_i2c_pkg::*;
#(
  parameter int RECOVER_TRIES = 9,
  parameter int HOLD_HALVES   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  op_e        op_i,
  input  logic [7:0] data_i,
  input  logic       rw_i,
  input  logic       tick,
  input  logic       sda_i,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       nack,
  output logic       scl_rel,
  output logic       sda_rel
);
  localparam int MAXA = (RECOVER_TRIES > HOLD_HALVES) ? RECOVER_TRIES : HOLD_HALVES;
  localparam int MAXC = (MAXA > 8) ? MAXA : 8;
  localparam int CNTW = $clog2(MAXC + 1);
  localparam logic [CNTW-1:0] LAST_TRY  = CNTW'(RECOVER_TRIES - 1);
  localparam logic [CNTW-1:0] HOLD_LAST = CNTW'(HOLD_HALVES - 1);

  seq_state_e state_q, state_d;
  op_e             op_q, op_d;
  logic [7:0]      sh_q, sh_d, rx_q, rx_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            scl_q, scl_d, sda_q, sda_d, nack_q, nack_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    cnt_d   = cnt_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    nack_d  = nack_q;
    done_d  = 1'b0;
    if (state_q == S_IDLE) begin
      if (go) begin
        op_d   = op_i;
        nack_d = 1'b0;
        case (op_i)
          OP_RECOVER: begin state_d = S_RC0; scl_d = 1'b0; sda_d = 1'b1; cnt_d = '0; end
          OP_START: begin
            state_d = S_STA0; scl_d = 1'b1; sda_d = 1'b1;
            sh_d = {data_i[6:0], rw_i};
          end
          OP_WRITE: begin
            state_d = S_WLO; scl_d = 1'b0; sda_d = data_i[7];
            sh_d = data_i; cnt_d = CNTW'(7);
          end
          OP_READ_ACK, OP_READ_NACK: begin
            state_d = S_RLO; scl_d = 1'b0; sda_d = 1'b1;
            sh_d = '0; cnt_d = CNTW'(7);
          end
          OP_STOP: begin state_d = S_SP0; scl_d = 1'b0; end
          default: state_d = S_IDLE;
        endcase
      end
    end else if (tick) begin
      case (state_q)
        S_STA0: begin state_d = S_STA1; sda_d = 1'b0; end
        S_STA1: begin state_d = S_STA2; scl_d = 1'b0; end
        S_STA2: begin state_d = S_WLO; sda_d = sh_q[7]; cnt_d = CNTW'(7); end
        S_WLO:  begin state_d = S_WHI; scl_d = 1'b1; end
        S_WHI: begin
          scl_d = 1'b0;
          if (cnt_q == '0) begin
            state_d = S_ALO; sda_d = 1'b1;
          end else begin
            state_d = S_WLO; sh_d = {sh_q[6:0], 1'b0};
            sda_d = sh_q[6]; cnt_d = cnt_q - CNTW'(1);
          end
        end
        S_ALO:  begin state_d = S_AHI; scl_d = 1'b1; end
        S_AHI:  begin state_d = S_TAIL; scl_d = 1'b0; nack_d = sda_i; end
        S_TAIL: begin state_d = S_IDLE; done_d = 1'b1; end
        S_RLO:  begin state_d = S_RHI; scl_d = 1'b1; end
        S_RHI: begin
          scl_d = 1'b0;
          sh_d  = {sh_q[6:0], sda_i};
          if (cnt_q == '0) begin
            rx_d = {sh_q[6:0], sda_i};
            if (op_q == OP_READ_ACK) begin
              state_d = S_MLO; sda_d = 1'b0;
            end else begin
              state_d = S_TAIL;
            end
          end else begin
            state_d = S_RLO; cnt_d = cnt_q - CNTW'(1);
          end
        end
        S_MLO:  begin state_d = S_MHI; scl_d = 1'b1; end
        S_MHI:  begin state_d = S_MEND; scl_d = 1'b0; end
        S_MEND: begin state_d = S_IDLE; sda_d = 1'b1; done_d = 1'b1; end
        S_SP0:  begin state_d = S_SP1; sda_d = 1'b0; end
        S_SP1:  begin state_d = S_SP2; scl_d = 1'b1; end
        S_SP2:  begin state_d = S_SP3; sda_d = 1'b1; end
        S_SP3:  begin state_d = S_HOLD; cnt_d = HOLD_LAST; end
        S_HOLD: begin
          if (cnt_q == '0) begin
            state_d = S_IDLE; done_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNTW'(1);
          end
        end
        S_RC0:  begin state_d = S_RCH; scl_d = 1'b1; end
        S_RCH: begin
          if (sda_i) begin
            state_d = S_RCD; sda_d = 1'b0;
          end else begin
            state_d = S_RCL; scl_d = 1'b0;
          end
        end
        S_RCL: begin
          if (cnt_q == LAST_TRY) begin
            state_d = S_IDLE; nack_d = 1'b1; done_d = 1'b1;
          end else begin
            state_d = S_RCH; scl_d = 1'b1; cnt_d = cnt_q + CNTW'(1);
          end
        end
        S_RCD: begin state_d = S_RCC; scl_d = 1'b0; end
        S_RCC: begin state_d = S_IDLE; done_d = 1'b1; end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_STOP;
      sh_q    <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      cnt_q   <= cnt_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      nack_q  <= nack_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign nack    = nack_q;
  assign scl_rel = scl_q;
  assign sda_rel = sda_q;

endmodule

// File: rtl/eeprom_i2c_engine.sv
module eeprom_i2c_engine
  import eeprom_i2c_pkg::*;
#(
  parameter int HALF_DIV      = 16,
  parameter int RECOVER_TRIES = 9,
  parameter int HOLD_HALVES   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_rw,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       nack,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic accept, tick, scl_rel, sda_rel;

  assign accept = cmd_valid && !busy && (cmd_op <= OP_STOP);

  i2c_half_timer #(.HALF_DIV(HALF_DIV)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .tick    (tick)
  );

  i2c_bit_seq #(
    .RECOVER_TRIES (RECOVER_TRIES),
    .HOLD_HALVES   (HOLD_HALVES)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (accept),
    .op_i    (op_e'(cmd_op)),
    .data_i  (cmd_data),
    .rw_i    (cmd_rw),
    .tick    (tick),
    .sda_i   (sda_in),
    .busy    (busy),
    .done    (done),
    .rx_byte (rx_byte),
    .nack    (nack),
    .scl_rel (scl_rel),
    .sda_rel (sda_rel)
  );

  assign scl_oe = !scl_rel;
  assign sda_oe = !sda_rel;

endmodule

// File: rtl/eeprom_i2c_engine_chk.sv
module eeprom_i2c_engine_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int HALF_DIV      = 16,
  parameter int RECOVER_TRIES = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe
);
  localparam int RW = $clog2(HALF_DIV + 1);
  localparam int TW = $clog2(RECOVER_TRIES + 2);

  logic          accept, scl_prev;
  logic [RW-1:0] run_cnt;
  logic [TW-1:0] pulses;
  op_e           op_q;

  assign accept = cmd_valid && !busy && (cmd_op <= OP_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b0;
      run_cnt  <= RW'(HALF_DIV);
      pulses   <= '0;
      op_q     <= OP_STOP;
    end else begin
      scl_prev <= scl_oe;
      if (scl_oe != scl_prev) run_cnt <= RW'(1);
      else if (run_cnt < RW'(HALF_DIV)) run_cnt <= run_cnt + RW'(1);
      if (accept) begin
        op_q   <= op_e'(cmd_op);
        pulses <= '0;
      end else if (scl_prev && !scl_oe && pulses <= TW'(RECOVER_TRIES)) begin
        pulses <= pulses + TW'(1);
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> ($stable(scl_oe) && $stable(sda_oe)));

  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (op_q == OP_START || op_q == OP_STOP || op_q == OP_RECOVER));

  assert_recover_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RECOVER) |-> (pulses <= TW'(RECOVER_TRIES)));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_done_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done == $fell(busy));

  assert_scl_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe != $past(scl_oe)) |-> (run_cnt >= RW'(HALF_DIV)));

endmodule

bind eeprom_i2c_engine eeprom_i2c_engine_chk #(
  .HALF_DIV      (HALF_DIV),
  .RECOVER_TRIES (RECOVER_TRIES)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe)
);

// File: tb/test_eeprom_i2c_engine.sv
module test_eeprom_i2c_engine;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       cmd_rw = 1'b0;
  logic       busy, done, nack, scl_oe, sda_oe, sda_in;
  logic [7:0] rx_byte;

  logic [63:0] drv_pat = 64'd0;
  logic [5:0]  fall_cnt;
  logic        slave_low, clr = 1'b0;
  logic        scl_p, sda_p;
  logic        cap [0:15];
  int rise_cnt, rise_tot, start_cnt, stop_cnt, hi_cnt, last_hi, stop_cyc, done_cyc;
  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign slave_low = drv_pat[fall_cnt];
  assign sda_in    = !(sda_oe || slave_low);

  eeprom_i2c_engine #(.HALF_DIV(HALF)) i_eeprom_i2c_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_rw(cmd_rw), .busy(busy), .done(done),
    .rx_byte(rx_byte), .nack(nack), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in)
  );

  // wire monitor: samples line levels between clock edges
  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = sda_in;
    if (!rst_n || clr) begin
      rise_cnt = 0; rise_tot = 0; fall_cnt = 6'd0;
      start_cnt = 0; stop_cnt = 0; hi_cnt = 0; last_hi = 0;
    end else begin
      if (scl_l && !scl_p) begin
        if (rise_cnt < 16) cap[rise_cnt] = sda_l;
        rise_cnt++; rise_tot++; hi_cnt = 1;
      end else if (scl_l) begin
        hi_cnt++;
      end
      if (!scl_l && scl_p) begin
        fall_cnt = fall_cnt + 6'd1; last_hi = hi_cnt;
      end
      if (scl_l && scl_p && sda_p && !sda_l) begin
        start_cnt++; rise_cnt = 0; fall_cnt = 6'd0;
      end
      if (scl_l && scl_p && !sda_p && sda_l) begin
        stop_cnt++; stop_cyc = cyc;
      end
    end
    scl_p = scl_l;
    sda_p = sda_l;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input string what, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cap_byte();
    return {cap[0], cap[1], cap[2], cap[3], cap[4], cap[5], cap[6], cap[7]};
  endfunction

  task automatic clear_mon();
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic rw);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_rw = rw;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk_true("R9", "done within limit", done, n, 5000);
    done_cyc = cyc;
    @(negedge clk);
    chk("R9", "done is a single-cycle pulse", done, 0);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input logic rw);
    clear_mon();
    issue(op, d, rw);
    wait_done();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "scl_oe after reset", scl_oe, 0);
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
  endtask

  task automatic t_recover(input int fails);
    drv_pat = 64'd0;
    for (int i = 1; i <= fails; i++) drv_pat[i] = 1'b1;
    run_cmd(3'd0, 8'd0, 1'b0);
    if (fails < 9) begin
      chk("R7", "SCL pulses until SDA seen high", rise_tot, fails + 1);
      chk("R7", "recovery result", nack, 0);
      chk("R7", "SCL held low at end", scl_oe, 1);
      chk("R7", "SDA held low at end", sda_oe, 1);
    end else begin
      chk("R8", "SCL pulses on failed recovery", rise_tot, 9);
      chk("R8", "failed recovery flag", nack, 1);
      chk("R8", "SCL low after failure", scl_oe, 1);
      chk("R8", "SDA released after failure", sda_oe, 0);
    end
  endtask

  task automatic t_stop();
    drv_pat = 64'd0;
    run_cmd(3'd5, 8'd0, 1'b0);
    chk("R6", "one stop condition seen", stop_cnt, 1);
    chk("R6", "SCL released after stop", scl_oe, 0);
    chk("R6", "SDA released after stop", sda_oe, 0);
    chk_true("R6", "bus-free hold cycles", (done_cyc - stop_cyc) >= 4 * HALF,
             done_cyc - stop_cyc, 4 * HALF);
  endtask

  task automatic t_start(input logic [6:0] ofs, input logic rw, input bit ack);
    drv_pat = 64'd0;
    drv_pat[9] = ack;
    run_cmd(3'd1, {1'b0, ofs}, rw);
    chk("R2", "start conditions seen", start_cnt, 1);
    chk("R2", "command byte on the wire", cap_byte(), {ofs, rw});
    chk("R4", "ack flag after command byte", nack, !ack);
  endtask

  task automatic t_write(input logic [7:0] d, input bit ack);
    drv_pat = 64'd0;
    drv_pat[8] = ack;
    run_cmd(3'd2, d, 1'b0);
    chk("R3", "written byte MSB first", cap_byte(), d);
    chk("R3", "SCL pulses for byte plus ack", rise_tot, 9);
    chk("R4", "ack flag after write", nack, !ack);
    chk("R10", "ack SCL high length", last_hi, HALF);
  endtask

  task automatic t_read(input logic [7:0] d, input bit more);
    drv_pat = 64'd0;
    for (int i = 0; i < 8; i++) drv_pat[i] = !d[7 - i];
    run_cmd(more ? 3'd3 : 3'd4, 8'd0, 1'b0);
    chk("R5", "received byte", rx_byte, d);
    chk("R5", "SCL pulses on read", rise_tot, more ? 9 : 8);
    if (more) chk("R5", "master ack level on ninth pulse", cap[8], 0);
    chk("R5", "SDA released after read", sda_oe, 0);
  endtask

  task automatic t_busy_ignore();
    drv_pat = 64'd0;
    drv_pat[8] = 1'b1;
    clear_mon();
    issue(3'd2, 8'h96, 1'b0);
    repeat (10) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk("R9", "byte intact despite command while busy", cap_byte(), 8'h96);
    chk("R9", "no stop from ignored command", stop_cnt, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (busy) seen++; end
      chk("R9", "no late start of ignored command", seen, 0);
    end
  endtask

  task automatic t_bad_code(input logic [2:0] code);
    logic s0, d0;
    int seen = 0;
    s0 = scl_oe; d0 = sda_oe;
    issue(code, 8'hFF, 1'b1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy || done) seen++; end
    chk("R9", "undefined code leaves engine idle", seen, 0);
    chk("R9", "undefined code leaves SCL", scl_oe, s0);
    chk("R9", "undefined code leaves SDA", sda_oe, d0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_recover(0);
    t_stop();
    t_recover(3);
    t_stop();
    t_recover(9);
    t_start(7'h55, 1'b1, 1'b1);
    t_write(8'hC3, 1'b1);
    t_write(8'h3C, 1'b0);
    t_read(8'hA5, 1'b1);
    t_read(8'h5A, 1'b0);
    t_stop();
    t_start(7'h00, 1'b0, 1'b0);
    t_stop();
    t_start(7'h7F, 1'b0, 1'b1);
    t_busy_ignore();
    t_bad_code(3'd6);
    t_bad_code(3'd7);
    t_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule